// File: doc/BRIEF.md
# SPI Frame Command Sequencer

This block runs one SPI frame per command word. A single 32-bit command names the chip select, the frame length, how many leading received bytes to throw away, and two flags: one for transmit-only frames and one for dual-line input during the read phase. The sequencer then steps through the frame one byte at a time. It takes outgoing bytes from a transmit FIFO and hands each byte to the bit shifter over a byte-exchange handshake. Received bytes that are kept go to a receive FIFO. The selected chip select stays asserted for the whole frame, and a one-cycle done pulse marks the end.

The receive-skip count lets a "send command, then read reply" exchange run as a single frame. The command bytes come from the transmit FIFO and their echoes are discarded. The reply bytes are clocked out with zero data and are stored. The read phase may also switch to dual-line input, which halves the shift time of each byte.

The machine has four states. IDLE waits for a command. LOAD fetches the next outgoing byte and stalls while that byte is needed and the FIFO is empty. SHIFT counts the byte's shift cycles. FINISH raises done and releases chip select.

The transitions are:

- IDLE to LOAD when a command is accepted.
- LOAD to SHIFT once the outgoing byte is available or is not needed.
- SHIFT to LOAD after the last shift cycle of a byte that is not the final one.
- SHIFT to FINISH after the last shift cycle of the final byte.
- FINISH to IDLE unconditionally.

Top module: `spi_frame_seq`

## Requirements
- R1: Command bits 31:30 select which active-low `cs_n` line is driven low. Exactly that line stays low from the cycle after the command is accepted through the done cycle. All lines are high whenever `busy` is low.
- R2: Command bits 15:0 hold the frame length minus one. A command with value L produces exactly L+1 byte exchanges (L+1 `link_done` pulses). It is followed by a single `done` pulse in the cycle after the last exchange, and then the block returns to idle.
- R3: Command bits 23:16 hold a skip count S. The received bytes of exchanges 0 to S-1 are not pushed. Each later exchange pushes its received byte (`link_rx_byte` sampled in the `link_done` cycle) to `rx_data` with `rx_push`. If S is larger than the frame, nothing is pushed.
- R4: Command bit 28 requests dual-line input. When S is nonzero, exchanges with index S or above run with `link_dual` high and last 4 shift cycles. All other exchanges last 8 shift cycles with `link_dual` low. When S is zero the bit is ignored.
- R5: Command bit 27 marks a transmit-only frame. No `rx_push` occurs during such a frame.
- R6: When S is zero, every exchange takes its byte from the transmit FIFO (one `tx_pop` each). When S is nonzero, only exchanges 0 to S-1 pop. The later exchanges send 0x00 and leave the FIFO untouched.
- R7: When an exchange needs a transmit byte and `tx_empty` is high, the block waits in LOAD with no pop, no exchange and chip select still asserted, until data arrives.
- R8: A command offered while `busy` is high is ignored: the running frame is unchanged, and `cmd_reject` is high in that cycle.
- R9: Each exchange takes one LOAD cycle (when data is ready) followed by its shift cycles, with `link_active` high. `link_tx_byte` is stable throughout, and `link_done` is high on the final shift cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word offered this cycle |
| cmd_word | input | 32 | Command: chip select, flags, skip count, length minus one |
| cmd_reject | output | 1 | Command offered while busy and ignored |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| cs_n | output | 4 | Active-low chip selects |
| tx_empty | input | 1 | Transmit FIFO has no data |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_pop | output | 1 | Consume the head transmit byte |
| link_active | output | 1 | Shifter is exchanging a byte |
| link_dual | output | 1 | Current exchange uses dual-line input |
| link_tx_byte | output | 8 | Byte being shifted out |
| link_rx_byte | input | 8 | Byte shifted in, valid on `link_done` |
| link_done | output | 1 | Final shift cycle of the current exchange |
| rx_push | output | 1 | Write `rx_data` to the receive FIFO |
| rx_data | output | 8 | Received byte to store |

## Verification
The bench runs several frame shapes against a behavioural model that is compared on every clock:

- A plain four-byte frame, which confirms full transmit sourcing and full storage.
- A skip frame with the dual flag and one surplus FIFO byte, which separates the popped command bytes from the zero-data read bytes and 8-cycle from 4-cycle exchanges.
- A dual request with no skip, which shows that the flag is ignored.
- A transmit-only frame.
- A frame whose skip count exceeds its length.
- A frame started on an empty FIFO, which exposes the stall.
- A second command sent mid-frame, which must be rejected without disturbing the chip select or the stored data.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam int CS_W     = 2;
    localparam int LEN_W    = 16;
    localparam int SKIP_W   = 8;
    localparam int BYTE_W   = 8;
    localparam int CMD_W    = 32;
    localparam int CS_LSB   = 30;
    localparam int DUAL_BIT = 28;
    localparam int TXO_BIT  = 27;
    localparam int SKIP_LSB = 16;
    localparam int LEN_LSB  = 0;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [CS_W-1:0]   cs;
        logic              tx_only;
        logic              dual;
        logic [SKIP_W-1:0] skip;
        logic [LEN_W-1:0]  last;
    } seq_cmd_t;
endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_seq_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output seq_cmd_t         cmd
);
    always_comb begin
        cmd.cs      = word[CS_LSB +: CS_W];
        cmd.tx_only = word[TXO_BIT];
        cmd.skip    = word[SKIP_LSB +: SKIP_W];
        cmd.last    = word[LEN_LSB +: LEN_W];
        // R4: dual input only honoured together with a nonzero skip count
        cmd.dual    = word[DUAL_BIT] && (word[SKIP_LSB +: SKIP_W] != '0);
    end
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
    parameter int SEL_W = 2,
    localparam int NCS  = 1 << SEL_W
) (
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic [NCS-1:0]   cs_n
);
    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign cs_n[i] = !(active && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
    import spi_seq_pkg::*;
#(
    parameter int SINGLE_CYCLES = 8,
    parameter int DUAL_CYCLES   = 4,
    localparam int NCS          = 1 << CS_W,
    localparam int CNT_W        = $clog2(SINGLE_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_reject,
    output logic              busy,
    output logic              done,
    output logic [NCS-1:0]    cs_n,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              link_active,
    output logic              link_dual,
    output logic [BYTE_W-1:0] link_tx_byte,
    input  logic [BYTE_W-1:0] link_rx_byte,
    output logic              link_done,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data
);
    seq_state_e        state, state_nx;
    seq_cmd_t          dec, cmd_q;
    logic [LEN_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] txb_q;
    logic              dual_act_q;
    logic [LEN_W-1:0]  skip_ext;
    logic              need_tx, in_read, load_go;

    spi_cmd_decode u_dec (.word(cmd_word), .cmd(dec));

    assign skip_ext = LEN_W'(cmd_q.skip);
    assign in_read  = idx_q >= skip_ext;
    assign need_tx  = (cmd_q.skip == '0) || !in_read;
    assign load_go  = !need_tx || !tx_empty;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cmd_valid) state_nx = ST_LOAD;
            ST_LOAD:   if (load_go) state_nx = ST_SHIFT;
            ST_SHIFT:  if (cnt_q == '0) state_nx = (idx_q == cmd_q.last) ? ST_FINISH : ST_LOAD;
            ST_FINISH: state_nx = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            idx_q      <= '0;
            cnt_q      <= '0;
            txb_q      <= '0;
            dual_act_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    cmd_q <= dec;
                    idx_q <= '0;
                end
                ST_LOAD: if (load_go) begin
                    txb_q      <= need_tx ? tx_data : '0;
                    dual_act_q <= cmd_q.dual && in_read;
                    cnt_q      <= (cmd_q.dual && in_read) ? CNT_W'(DUAL_CYCLES - 1)
                                                          : CNT_W'(SINGLE_CYCLES - 1);
                end
                ST_SHIFT: begin
                    if (cnt_q != '0)                cnt_q <= cnt_q - 1'b1;
                    else if (idx_q != cmd_q.last)   idx_q <= idx_q + 1'b1;
                end
                ST_FINISH: ;
            endcase
        end
    end

    spi_cs_drive #(.SEL_W(CS_W)) u_cs (.active(busy), .sel(cmd_q.cs), .cs_n(cs_n));

    // outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        done         = (state == ST_FINISH);
        cmd_reject   = cmd_valid && busy;
        tx_pop       = (state == ST_LOAD) && need_tx && !tx_empty;
        link_active  = (state == ST_SHIFT);
        link_dual    = link_active && dual_act_q;
        link_tx_byte = txb_q;
        link_done    = link_active && (cnt_q == '0);
        rx_push      = link_done && in_read && !cmd_q.tx_only;
        rx_data      = link_rx_byte;
    end

    p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
    p_cs_release_r1: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (&cs_n));
    p_cs_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n));
    p_done_after_xchg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(link_done));
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
    p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> (idx_q >= skip_ext));
    p_dual_skip_r4: assert property (@(posedge clk) disable iff (!rst_n) link_dual |-> (cmd_q.skip != '0));
    p_txonly_r5: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> !cmd_q.tx_only);
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> !tx_empty);
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n) cmd_reject |=> busy);
    p_txbyte_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_active && $past(link_active) && !$past(link_done)) |-> $stable(link_tx_byte));
endmodule

// File: tb/spi_frame_seq_test.sv
module spi_frame_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_reject, busy, done, tx_pop, link_active, link_dual, link_done, rx_push;
    logic [3:0]  cs_n;
    logic        tx_empty = 1'b1;
    logic [7:0]  tx_data = '0;
    logic [7:0]  link_tx_byte, rx_data;
    logic [7:0]  link_rx_byte = 8'h40;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [7:0] txq[$];
    logic [7:0] gotq[$];

    // model state
    bit m_act = 0; int m_ph = 0, m_cnt = 0, m_idx = 0, m_last = 0, m_skip = 0, m_cs = 0;
    bit m_to = 0, m_dual = 0, m_dact = 0; logic [7:0] m_txb = 0;

    always #5 clk = ~clk;

    spi_frame_seq uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_reject(cmd_reject), .busy(busy), .done(done), .cs_n(cs_n), .tx_empty(tx_empty),
        .tx_data(tx_data), .tx_pop(tx_pop), .link_active(link_active), .link_dual(link_dual),
        .link_tx_byte(link_tx_byte), .link_rx_byte(link_rx_byte), .link_done(link_done),
        .rx_push(rx_push), .rx_data(rx_data));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void refresh();
        tx_empty = (txq.size() == 0);
        tx_data  = tx_empty ? 8'h00 : txq[0];
    endfunction

    // FIFO and link source updates just after each edge
    always @(posedge clk) begin
        automatic bit p = tx_pop, d = link_done;
        #1;
        if (p && txq.size() > 0) void'(txq.pop_front());
        if (d) link_rx_byte = link_rx_byte + 8'h01;
        refresh();
    end

    // per-cycle comparison with the behavioural model
    always @(negedge clk) if (rst_n && !finished) begin
        automatic bit need = (m_skip == 0) || (m_idx < m_skip);
        automatic bit e_lact = m_act && m_ph == 1;
        automatic bit e_ldone = e_lact && m_cnt == 0;
        automatic bit e_push = e_ldone && !m_to && m_idx >= m_skip;
        automatic logic [3:0] e_cs = m_act ? ~(4'b1 << m_cs) : 4'hF;
        chk(busy == m_act, "R2 busy", busy, m_act);
        chk(cs_n == e_cs, "R1 cs_n", cs_n, e_cs);
        chk(done == (m_act && m_ph == 2), "R2 done", done, m_act && m_ph == 2);
        chk(tx_pop == (m_act && m_ph == 0 && need && !tx_empty), "R6/R7 tx_pop", tx_pop, 0);
        chk(link_active == e_lact, "R9 link_active", link_active, e_lact);
        chk(link_done == e_ldone, "R9 link_done", link_done, e_ldone);
        chk(link_dual == (e_lact && m_dact), "R4 link_dual", link_dual, e_lact && m_dact);
        chk(rx_push == e_push, "R3/R5 rx_push", rx_push, e_push);
        chk(cmd_reject == (cmd_valid && m_act), "R8 cmd_reject", cmd_reject, cmd_valid && m_act);
        if (e_lact) chk(link_tx_byte == m_txb, "R6 link_tx_byte", link_tx_byte, m_txb);
        if (rx_push) begin
            chk(rx_data == link_rx_byte, "R3 rx_data", rx_data, link_rx_byte);
            gotq.push_back(rx_data);
        end
        // advance model to the next cycle
        if (!m_act) begin
            if (cmd_valid) begin
                m_act = 1; m_ph = 0; m_idx = 0;
                m_cs = cmd_word[31:30]; m_to = cmd_word[27]; m_skip = cmd_word[23:16];
                m_last = cmd_word[15:0]; m_dual = cmd_word[28] && (cmd_word[23:16] != 0);
            end
        end else if (m_ph == 0) begin
            if (!need || !tx_empty) begin
                m_txb = need ? tx_data : 8'h00;
                m_dact = m_dual && m_idx >= m_skip;
                m_cnt = m_dact ? 3 : 7;
                m_ph = 1;
            end
        end else if (m_ph == 1) begin
            if (m_cnt > 0) m_cnt--;
            else if (m_idx == m_last) m_ph = 2;
            else begin m_idx++; m_ph = 0; end
        end else m_act = 0;
    end

    task automatic send(input logic [31:0] w);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_word = w;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) return;
        end
        chk(0, "R2 done never seen", 0, 1);
    endtask

    function automatic logic [31:0] mk(int cs, bit dual, bit txo, int skip, int last);
        return {cs[1:0], 1'b0, dual, txo, 3'b0, skip[7:0], last[15:0]};
    endfunction

    // check stored bytes against the expected link values
    task automatic frame_check(input string req, input logic [7:0] base, input int skip, input int last, input bit txo);
        automatic int n = 0;
        if (!txo) for (int i = skip; i <= last; i++) begin
            if (n < gotq.size()) chk(gotq[n] == 8'(base + i), req, gotq[n], 8'(base + i));
            n++;
        end
        chk(gotq.size() == n, {req, " count"}, gotq.size(), n);
        gotq.delete();
    endtask

    initial begin
        automatic logic [7:0] base;
        #1;
        @(negedge clk);
        chk(cs_n == 4'hF && !busy && !done, "R1 reset state", cs_n, 4'hF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2/R6: plain 4-byte frame on cs1, all bytes sourced and stored
        txq = '{8'h11, 8'h22, 8'h33, 8'h44}; refresh();
        base = link_rx_byte;
        send(mk(1, 0, 0, 0, 3)); wait_done();
        frame_check("R2 plain frame data", base, 0, 3, 0);
        chk(txq.size() == 0, "R6 all bytes popped", txq.size(), 0);

        // R3/R4/R6: skip 2 + dual, 6 bytes, one surplus FIFO byte must remain
        txq = '{8'hA1, 8'hA2, 8'hA3}; refresh();
        base = link_rx_byte;
        send(mk(2, 1, 0, 2, 5)); wait_done();
        frame_check("R3 skip frame data", base, 2, 5, 0);
        chk(txq.size() == 1, "R6 only skip bytes popped", txq.size(), 1);
        txq.delete(); refresh();

        // R4: dual requested with zero skip is ignored (model expects 8 cycles)
        txq = '{8'h5A}; refresh();
        base = link_rx_byte;
        send(mk(0, 1, 0, 0, 0)); wait_done();
        frame_check("R4 dual ignored data", base, 0, 0, 0);

        // R5: transmit-only frame stores nothing
        txq = '{8'h01, 8'h02, 8'h03}; refresh();
        base = link_rx_byte;
        send(mk(3, 0, 1, 0, 2)); wait_done();
        frame_check("R5 tx-only", base, 0, 2, 1);

        // R3: skip longer than frame, nothing stored, all bytes popped
        txq = '{8'h77, 8'h78}; refresh();
        base = link_rx_byte;
        send(mk(1, 0, 0, 5, 1)); wait_done();
        frame_check("R3 skip beyond length", base, 5, 1, 0);
        chk(txq.size() == 0, "R6 skip-long pops", txq.size(), 0);

        // R7: start on an empty FIFO, stall then resume
        base = link_rx_byte;
        send(mk(2, 0, 0, 0, 1));
        repeat (10) @(negedge clk);
        chk(busy && cs_n == 4'b1011 && !link_active, "R7 stall holds cs", cs_n, 4'b1011);
        @(posedge clk); #2; txq.push_back(8'hC1); txq.push_back(8'hC2); refresh();
        wait_done();
        frame_check("R7 post-stall data", base, 0, 1, 0);

        // R8: command during a frame is ignored
        txq = '{8'hD1, 8'hD2}; refresh();
        base = link_rx_byte;
        send(mk(0, 0, 0, 0, 1));
        repeat (3) @(negedge clk);
        send(mk(3, 0, 1, 0, 9));
        @(negedge clk);
        chk(cs_n == 4'b1110, "R8 cs unchanged", cs_n, 4'b1110);
        wait_done();
        frame_check("R8 original frame intact", base, 0, 1, 0);
        repeat (3) @(negedge clk);
        chk(!busy, "R8 no second frame", busy, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule